// File: doc/BRIEF.md
# One-Shot Digital Capture Buffer

This block records one asynchronous digital line at the full system clock rate, acting as the storage stage of a simple logic analyser. The line first crosses into the clock domain through a chain of flip-flops. After that, one sample is taken on every clock. Each group of eight consecutive samples is gathered into a byte and written into on-chip RAM as the eighth sample arrives. There are no gaps in sampling. Capture starts on its own when reset is released. It halts once the buffer holds `DEPTH` bytes (`DEPTH*8` samples) and raises `done`. Pulsing `restart` re-arms the capture without a full reset.

A separate reader drains the stored bytes through a valid/ready byte stream. The reader runs at whatever pace the downstream host link allows and never waits on capture. It may run while capture is still filling the buffer. It only offers a byte once that byte has been completely written.

Capture control is a two-state machine. `CAP_FILL` samples every clock. It moves to `CAP_FULL` on the clock that takes the final sample. `CAP_FULL` holds until `restart` sends it back to `CAP_FILL`. The reader has three states. `RD_SCAN` waits until the read pointer is behind the written-byte count and then moves to `RD_FETCH`. `RD_FETCH` lets the RAM read complete, latches the byte and moves to `RD_OFFER`. `RD_OFFER` drives `rd_valid` and returns to `RD_SCAN` when `rd_ready` is high. `restart` forces the reader to `RD_SCAN` with a zero pointer.

Top module: `sigcap_buffer`

## Requirements
- R1: `sig_in` is sampled only after passing two clocked flip-flops. The sample taken on a clock edge equals the value `sig_in` held two edges earlier. After reset the synchroniser holds 0, so the first two samples after reset are 0.
- R2: Capture is gap-free. The sample on the k-th edge after reset release (k counted from 0) is stored as bit (k mod 8) of byte floor(k/8).
- R3: Within each byte, the earliest sample is in bit 0 and the latest sample is in bit 7.
- R4: Capture starts by itself after reset. `done` is 0 until the edge that takes sample `DEPTH*8-1`, and it is 1 after that edge.
- R5: Once the buffer is full, no further samples are written. Exactly `DEPTH` bytes are delivered. After the last byte is delivered, `rd_valid` stays 0 until a new byte is written.
- R6: A byte is consumed only on an edge where `rd_valid` and `rd_ready` are both 1. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` hold their values.
- R7: The reader never overtakes the writer. Byte i is offered only after the edge that wrote its eighth sample has passed.
- R8: `done` stays 1 until reset or `restart`.
- R9: A one-cycle `restart` clears `done` and both pointers, and drops `rd_valid`. Capture resumes at byte 0 on the next edge. The synchroniser is not cleared, so that first sample is whatever the synchroniser already holds.
- R10: While reset is asserted, `rd_valid` and `done` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_in | input | 1 | Asynchronous digital line being captured |
| restart | input | 1 | One-cycle pulse that re-arms capture |
| rd_ready | input | 1 | Downstream can accept a byte this cycle |
| rd_valid | output | 1 | `rd_data` holds a stored byte on offer |
| rd_data | output | 8 | Stored byte; earliest sample in bit 0 |
| done | output | 1 | Buffer full; capture halted |

## Verification
Each input level is due in the stored data two edges after it is driven, so the expected byte images are built from the driven pattern with that two-sample lag. After `restart` the lag is one sample, and the leading sample is the level held before the pulse. `done` is due exactly after the edge that takes sample `DEPTH*8-1`, counted from reset release (or one edge later, counted from the `restart` edge). The bench counts falling edges to check that `done` is low one edge before and high on that edge. A byte reaches `rd_valid` two edges after its writing edge. The bench drives inputs and reads outputs only at falling edges. It decides `rd_ready` before recording a handshake, so the byte it records is the one the next rising edge consumes.

// File: rtl/cap_pkg.sv
package cap_pkg;
    typedef enum logic [0:0] {
        CAP_FILL = 1'b0,
        CAP_FULL = 1'b1
    } cap_state_t;

    typedef enum logic [1:0] {
        RD_SCAN  = 2'd0,
        RD_FETCH = 2'd1,
        RD_OFFER = 2'd2
    } rd_state_t;
endpackage

// File: rtl/sigcap_sync.sv
module sigcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sigcap_packer.sv
module sigcap_packer #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          sample_en,
    input  logic          bit_in,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          last_sample,
    output logic [AW:0]   bytes_done
);
    localparam int CW    = AW + 3;
    localparam int NBITS = DEPTH * 8;

    logic [CW-1:0] wcount;
    logic [6:0]    shreg;

    always_comb begin
        wr_en       = sample_en && (wcount[2:0] == 3'd7);
        wr_addr     = wcount[CW-1:3];
        wr_data     = {bit_in, shreg};
        last_sample = sample_en && (wcount == CW'(NBITS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcount     <= '0;
            shreg      <= '0;
            bytes_done <= '0;
        end else if (clear) begin
            wcount     <= '0;
            shreg      <= '0;
            bytes_done <= '0;
        end else if (sample_en) begin
            wcount <= wcount + 1'b1;
            shreg  <= {bit_in, shreg[6:1]};
            if (wr_en) bytes_done <= bytes_done + 1'b1;
        end
    end

    AST_BYTE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        bytes_done <= (AW+1)'(DEPTH)); // R5
endmodule

// File: rtl/sigcap_ram.sv
module sigcap_ram #(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    q
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        q <= mem[raddr];
    end
endmodule

// File: rtl/sigcap_reader.sv
module sigcap_reader
    import cap_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [AW:0]   avail,
    input  logic [7:0]    ram_q,
    input  logic          rd_ready,
    output logic [AW-1:0] ram_raddr,
    output logic          rd_valid,
    output logic [7:0]    rd_data
);
    rd_state_t   state, next_state;
    logic [AW:0] rptr;
    logic [7:0]  data_q;

    always_comb begin
        next_state = state;
        unique case (state)
            RD_SCAN:  if (rptr < avail) next_state = RD_FETCH;
            RD_FETCH: next_state = RD_OFFER;
            RD_OFFER: if (rd_ready) next_state = RD_SCAN;
            default:  next_state = RD_SCAN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     state <= RD_SCAN;
        else if (clear) state <= RD_SCAN;
        else            state <= next_state;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr   <= '0;
            data_q <= '0;
        end else if (clear) begin
            rptr <= '0;
        end else if (state == RD_FETCH) begin
            data_q <= ram_q;
            rptr   <= rptr + 1'b1;
        end
    end

    always_comb begin
        rd_valid  = (state == RD_OFFER);
        rd_data   = data_q;
        ram_raddr = rptr[AW-1:0];
    end

    AST_NO_OVERTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        rptr <= avail); // R7
    AST_HOLD_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready && !clear |=> rd_valid && $stable(rd_data)); // R6
endmodule

// File: rtl/sigcap_buffer.sv
module sigcap_buffer
    import cap_pkg::*;
#(
    parameter int DEPTH       = 1024,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_in,
    input  logic       restart,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       done
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    cap_state_t    state, next_state;
    logic          sample_bit;
    logic          sample_en;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          last_sample;
    logic [AW:0]   bytes_done;
    logic [AW-1:0] ram_raddr;
    logic [7:0]    ram_q;

    sigcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (sig_in),
        .q    (sample_bit)
    );

    always_comb begin
        next_state = state;
        unique case (state)
            CAP_FILL: if (last_sample) next_state = CAP_FULL;
            CAP_FULL: next_state = CAP_FULL;
            default:  next_state = CAP_FILL;
        endcase
        if (restart) next_state = CAP_FILL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CAP_FILL;
        else        state <= next_state;
    end

    always_comb begin
        sample_en = (state == CAP_FILL) && !restart;
        done      = (state == CAP_FULL);
    end

    sigcap_packer #(.DEPTH(DEPTH), .AW(AW)) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (restart),
        .sample_en  (sample_en),
        .bit_in     (sample_bit),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .last_sample(last_sample),
        .bytes_done (bytes_done)
    );

    sigcap_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk  (clk),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(ram_raddr),
        .q    (ram_q)
    );

    sigcap_reader #(.DEPTH(DEPTH), .AW(AW)) u_reader (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (restart),
        .avail    (bytes_done),
        .ram_q    (ram_q),
        .rd_ready (rd_ready),
        .ram_raddr(ram_raddr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done && !restart |=> done); // R8
    AST_RESTART_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !done && !rd_valid); // R9
    AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !wr_en); // R5
endmodule

// File: tb/sigcap_buffer_bench.sv
module sigcap_buffer_bench;
    localparam int DEPTH = 8;
    localparam int N     = DEPTH * 8;
    localparam int NPAT  = 5;

    // stimulus table: raw input pattern (bit j driven before edge j) and read mode
    localparam logic [63:0] PATS [NPAT] = '{
        64'h0000_0000_0000_0000,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'hAAAA_5555_CCCC_3333,
        64'h0F1E_2D3C_4B5A_6978,
        64'h0000_0000_0000_0001   // single pulse: R1 lag and R3 bit order
    };
    localparam logic CONC [NPAT] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sig_in = 1'b0;
    logic       restart = 1'b0;
    logic       rd_ready = 1'b0;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       done;

    int tests = 0;
    int fails = 0;
    int nr;
    logic [7:0] got [DEPTH];
    logic [7:0] expb [DEPTH];

    always #10 clk = ~clk;

    sigcap_buffer #(.DEPTH(DEPTH)) u_sigcap_buffer (
        .clk     (clk),
        .rst_n   (rst_n),
        .sig_in  (sig_in),
        .restart (restart),
        .rd_ready(rd_ready),
        .rd_valid(rd_valid),
        .rd_data (rd_data),
        .done    (done)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic build_expected(input logic [63:0] pat, input int lag, input logic c0);
        for (int k = 0; k < N; k++) begin
            logic s;
            s = (k < lag) ? c0 : pat[k - lag];
            expb[k / 8][k % 8] = s;
        end
    endtask

    // capture phase; lag=0 after reset start, lag=1 after restart
    task automatic fill(input logic [63:0] pat, input int lag, input logic conc);
        for (int j = 1; j <= N + lag + 6; j++) begin
            @(negedge clk);
            if (lag == 1 && j == 1) begin
                check(done == 1'b0, "R9 done cleared", done, 0);
                check(rd_valid == 1'b0, "R9 valid dropped", rd_valid, 0);
                restart = 1'b0;
            end
            if (j - lag == N - 1) check(done == 1'b0, "R4 done early", done, 0);
            if (j - lag == N)     check(done == 1'b1, "R4 done due", done, 1);
            if (conc && rd_valid && rd_ready && nr < DEPTH) begin
                check(j - lag >= 8 * nr + 8, "R7 byte offered before written", j - lag, 8 * nr + 8);
                got[nr] = rd_data;
                nr++;
            end
            sig_in = (j < 64) ? pat[j] : ~sig_in;
            rd_ready = conc;
        end
    endtask

    task automatic drain();
        logic pv, pr;
        logic [7:0] pd;
        pv = 1'b0; pr = 1'b0; pd = '0;
        for (int c = 0; c < 400 && nr < DEPTH; c++) begin
            @(negedge clk);
            if (rd_valid && pv && !pr)
                check(rd_data == pd, "R6 data held while stalled", rd_data, pd);
            rd_ready = ((c % 3) != 1);
            if (rd_valid && rd_ready) begin
                got[nr] = rd_data;
                nr++;
            end
            pv = rd_valid; pr = rd_ready; pd = rd_data;
            sig_in = ~sig_in;
        end
        rd_ready = 1'b1;
        repeat (8) @(negedge clk);
        check(nr == DEPTH, "R5 byte count", nr, DEPTH);
        check(rd_valid == 1'b0, "R5 valid after last byte", rd_valid, 0);
        check(done == 1'b1, "R8 done held", done, 1);
        for (int i = 0; i < DEPTH; i++)
            check(got[i] == expb[i], "R1/R2/R3 stored byte", got[i], expb[i]);
        rd_ready = 1'b0;
    endtask

    task automatic start_from_reset(input logic [63:0] pat);
        rst_n = 1'b0; restart = 1'b0; rd_ready = 1'b0; sig_in = 1'b0;
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R10 valid in reset", rd_valid, 0);
        check(done == 1'b0, "R10 done in reset", done, 0);
        rst_n = 1'b1;
        sig_in = pat[0];
        nr = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // table walk
        for (int t = 0; t < NPAT; t++) begin
            build_expected(PATS[t], 2, 1'b0);
            start_from_reset(PATS[t]);
            fill(PATS[t], 0, CONC[t]);
            drain();
        end
        // directed: single pulse lands in bit 2 of byte 0 (R1, R3)
        build_expected(PATS[4], 2, 1'b0);
        check(expb[0] == 8'h04, "R3 pulse image", expb[0], 8'h04);

        // directed: fill without reading, done sticky, then restart mid-offer
        start_from_reset(PATS[3]);
        fill(PATS[3], 0, 1'b0);
        sig_in = 1'b1;
        for (int w = 0; w < 5; w++) begin
            @(negedge clk);
            check(done == 1'b1, "R8 done sticky", done, 1);
        end
        check(rd_valid == 1'b1, "R6 byte on offer while stalled", rd_valid, 1);
        build_expected(PATS[2], 1, 1'b1);
        restart = 1'b1;
        sig_in = PATS[2][0];
        nr = 0;
        fill(PATS[2], 1, 1'b0);
        drain();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule